// File: doc/BRIEF.md
# Three-Bus Register-File Datapath

This block is the main data path of a small microcoded processor. Each cycle, two read addresses place register contents on an A bus and a B bus. Both buses feed an arithmetic/logic unit. Its output passes through a one-position shifter and, when the load control is high, is captured in a result latch. In the following cycle the latched value is written over the C bus into the register chosen by the C address given with the capture. An external sequencer supplies every control field each cycle. The sequence of those fields is the microprogram: for example, the five operations that fetch an instruction, advance the program counter, keep the opcode, fetch the operand and add it to the accumulator.

Eight 16-bit registers sit in fixed slots. Slot 0 is a scratch register and slot 1 is a read-only constant one. Slots 2, 3 and 4 hold the program counter, instruction register and accumulator, and slot 5 is general purpose. Slot 6 is the memory address register and slot 7 is the memory buffer register. Memory operands reach the ALU directly from slot 7, because any slot can be on either bus.

The memory port follows a valid/ready rule. `mem_req` stays high for as long as the access control is held, and a transfer happens only on a clock edge where `mem_req` and `mem_ready` are both high. The sequencer keeps the controls steady until that edge, so a low `mem_ready` simply stretches the access. The block never drops or repeats a transfer on its own.

Top module: `tribus_datapath`

## Requirements
- R1: While `rst_n` is low, every register reads zero except slot 1, `result` is zero and no write-back is pending.
- R2: Slot 1 reads as 0x0001 on both buses at all times, and a write-back addressed to slot 1 changes nothing.
- R3: `a_bus` and `b_bus` show the slot selected by `a_sel` and `b_sel` combinationally. The slots are: 0 scratch, 2 program counter, 3 instruction, 4 accumulator, 5 general, 6 address, 7 buffer.
- R4: `alu_fn` encodings are 0 pass A, 1 pass B, 2 A AND B, 3 A OR B, 4 NOT A, 5 A+B, 6 A−B and 7 A XOR B, all modulo 2^16.
- R5: `sh_fn` encodings are 0 no shift, 1 shift left one with a zero filled in, 2 logical shift right one, and 3 no shift. On an edge with `res_ld` high, `result` takes the shifter output; otherwise `result` holds.
- R6: On the edge after a capture, the latched value is written to the slot named by `c_sel` at capture time. A read in the cycle between capture and write sees the old register value, because there is no forwarding.
- R7: `mem_addr` always equals slot 6 and `mem_wdata` always equals slot 7. `mem_req` equals `ma`, and `mem_we` equals `ma` AND `wr`.
- R8: On an edge with `ma`=1, `wr`=0, `mbr_sel`=1 and `mem_ready`=1, slot 7 takes `mem_rdata`. With `mem_ready` low it holds.
- R9: Slot 7 takes a C-bus write-back only when `mbr_sel` is 0 in the write cycle. With `mbr_sel`=1 such a write-back is dropped.
- R10: With `ma`=1 and `wr`=1, memory stores slot 7 at the address in slot 6 on the first edge where `mem_ready` is high.
- R11: The five-operation fetch/advance/decode/operand/add sequence leaves the accumulator equal to its old value plus memory at the fetched operand address, and leaves the program counter advanced by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 3 | A bus source slot |
| b_sel | input | 3 | B bus source slot |
| c_sel | input | 3 | Destination slot, sampled with `res_ld` |
| alu_fn | input | 3 | ALU function code |
| sh_fn | input | 2 | Shifter code |
| res_ld | input | 1 | Capture shifter output into result latch |
| mbr_sel | input | 1 | Buffer input mux: 1 memory, 0 C bus |
| ma | input | 1 | Memory access request |
| wr | input | 1 | Access direction: 1 write, 0 read |
| mem_ready | input | 1 | Memory accepts/returns this cycle |
| mem_rdata | input | 16 | Memory read data |
| mem_req | output | 1 | Memory transfer valid |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address (slot 6) |
| mem_wdata | output | 16 | Memory write data (slot 7) |
| a_bus | output | 16 | A bus value |
| b_bus | output | 16 | B bus value |
| result | output | 16 | Result latch |

## Verification
The bench targets the one-cycle gap between capture and write-back. A design that forwarded or wrote early would show the new value on a bus one cycle too soon. It stalls reads with `mem_ready` low and expects the buffer to stay put; a design that ignored the handshake would load stale data. It aims write-backs at slot 1 and, with `mbr_sel` high, at slot 7; a wrong mux would let those clobber the constant or the buffer. It also runs all eight ALU codes and both shift directions against known operands, where a swapped subtract order or an arithmetic right shift shows at once.

// File: rtl/tribus_pkg.sv
package tribus_pkg;
  typedef enum logic [2:0] {
    ALU_PASS_A = 3'd0,
    ALU_PASS_B = 3'd1,
    ALU_AND    = 3'd2,
    ALU_OR     = 3'd3,
    ALU_NOT_A  = 3'd4,
    ALU_ADD    = 3'd5,
    ALU_SUB    = 3'd6,
    ALU_XOR    = 3'd7
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_LEFT  = 2'd1,
    SH_RIGHT = 2'd2,
    SH_PASS  = 2'd3
  } sh_fn_e;

  localparam int unsigned SLOT_TMP = 0;
  localparam int unsigned SLOT_ONE = 1;
  localparam int unsigned SLOT_PC  = 2;
  localparam int unsigned SLOT_IR  = 3;
  localparam int unsigned SLOT_ACC = 4;
  localparam int unsigned SLOT_MAR = 6;
  localparam int unsigned SLOT_MBR = 7;
endpackage

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    fn,
  output logic [DW-1:0] y
);
  alu_fn_e op;
  assign op = alu_fn_e'(fn);

  always_comb begin
    unique case (op)
      ALU_PASS_A: y = a;
      ALU_PASS_B: y = b;
      ALU_AND:    y = a & b;
      ALU_OR:     y = a | b;
      ALU_NOT_A:  y = ~a;
      ALU_ADD:    y = a + b;
      ALU_SUB:    y = a - b;
      ALU_XOR:    y = a ^ b;
      default:    y = a;
    endcase
  end
endmodule

// File: rtl/tribus_shifter.sv
module tribus_shifter
  import tribus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] x,
  input  logic [1:0]    fn,
  output logic [DW-1:0] y
);
  sh_fn_e op;
  assign op = sh_fn_e'(fn);

  always_comb begin
    unique case (op)
      SH_LEFT:  y = {x[DW-2:0], 1'b0};
      SH_RIGHT: y = {1'b0, x[DW-1:1]};
      default:  y = x;
    endcase
  end
endmodule

// File: rtl/tribus_regfile.sv
module tribus_regfile
  import tribus_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_sel,
  input  logic [AW-1:0] b_sel,
  output logic [DW-1:0] a_bus,
  output logic [DW-1:0] b_bus,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_slot,
  input  logic [DW-1:0] wb_data,
  input  logic          mbr_sel,
  input  logic          mem_load,
  input  logic [DW-1:0] mem_data,
  output logic [DW-1:0] mar_q,
  output logic [DW-1:0] mbr_q
);
  logic [DW-1:0] slot_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic hit;
    assign hit = wb_en && (wb_slot == AW'(i));

    if (i == SLOT_ONE) begin : g_const
      assign slot_q[i] = DW'(1);
    end else if (i == SLOT_MBR) begin : g_buf
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)              q <= '0;
        else if (mem_load)       q <= mem_data;
        else if (hit && !mbr_sel) q <= wb_data;
      end
      assign slot_q[i] = q;
    end else begin : g_gp
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wb_data;
      end
      assign slot_q[i] = q;
    end
  end

  assign a_bus = slot_q[a_sel];
  assign b_bus = slot_q[b_sel];
  assign mar_q = slot_q[SLOT_MAR];
  assign mbr_q = slot_q[SLOT_MBR];
endmodule

// File: rtl/tribus_datapath.sv
module tribus_datapath
  import tribus_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_sel,
  input  logic [AW-1:0] b_sel,
  input  logic [AW-1:0] c_sel,
  input  logic [2:0]    alu_fn,
  input  logic [1:0]    sh_fn,
  input  logic          res_ld,
  input  logic          mbr_sel,
  input  logic          ma,
  input  logic          wr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] a_bus,
  output logic [DW-1:0] b_bus,
  output logic [DW-1:0] result
);
  logic [DW-1:0] alu_y;
  logic [DW-1:0] sh_y;
  logic [DW-1:0] res_q;
  logic          wb_pend;
  logic [AW-1:0] wb_addr;
  logic          mem_load;

  assign mem_load = ma && !wr && mem_ready && mbr_sel;

  tribus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_sel    (a_sel),
    .b_sel    (b_sel),
    .a_bus    (a_bus),
    .b_bus    (b_bus),
    .wb_en    (wb_pend),
    .wb_slot  (wb_addr),
    .wb_data  (res_q),
    .mbr_sel  (mbr_sel),
    .mem_load (mem_load),
    .mem_data (mem_rdata),
    .mar_q    (mem_addr),
    .mbr_q    (mem_wdata)
  );

  tribus_alu #(.DW(DW)) u_alu (
    .a  (a_bus),
    .b  (b_bus),
    .fn (alu_fn),
    .y  (alu_y)
  );

  tribus_shifter #(.DW(DW)) u_sh (
    .x  (alu_y),
    .fn (sh_fn),
    .y  (sh_y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      wb_pend <= 1'b0;
      wb_addr <= '0;
    end else begin
      if (res_ld) res_q <= sh_y;
      wb_pend <= res_ld;
      wb_addr <= c_sel;
    end
  end

  assign result  = res_q;
  assign mem_req = ma;
  assign mem_we  = ma && wr;
endmodule

// File: rtl/tribus_datapath_chk.sv
module tribus_datapath_chk #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] a_sel,
  input logic [DW-1:0] a_bus,
  input logic          res_ld,
  input logic [DW-1:0] sh_y,
  input logic [DW-1:0] result,
  input logic          ma,
  input logic          wr,
  input logic          mbr_sel,
  input logic          mem_ready,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_addr,
  input logic          wb_pend,
  input logic [AW-1:0] wb_addr
);
  p_one_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel == AW'(1)) |-> (a_bus == DW'(1)));

  p_res_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_ld |=> (result == $past(sh_y)));

  p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ld |=> $stable(result));

  p_mar_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_pend && wb_addr == AW'(6)) |=> (mem_addr == $past(result)));

  p_mem_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ma && !wr && mem_ready && mbr_sel) |=> (mem_wdata == $past(mem_rdata)));

  p_mbr_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mbr_sel && !(ma && !wr && mem_ready)) |=> $stable(mem_wdata));
endmodule

bind tribus_datapath tribus_datapath_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/tribus_datapath_tb.sv
`timescale 1ns/1ps
module tribus_datapath_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  a_sel, b_sel, c_sel, alu_fn;
  logic [1:0]  sh_fn;
  logic        res_ld, mbr_sel, ma, wr, mem_ready;
  logic [15:0] mem_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata, a_bus, b_bus, result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] mem [256];
  logic [15:0] mr [8];
  logic [15:0] mres;
  bit          mwbp;
  logic [2:0]  mwba;

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  tribus_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .b_sel(b_sel), .c_sel(c_sel),
    .alu_fn(alu_fn), .sh_fn(sh_fn), .res_ld(res_ld), .mbr_sel(mbr_sel),
    .ma(ma), .wr(wr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .a_bus(a_bus), .b_bus(b_bus), .result(result)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] rd(input logic [2:0] s);
    return (s == 3'd1) ? 16'h0001 : mr[s];
  endfunction

  function automatic logic [15:0] calc(input logic [15:0] a, input logic [15:0] b,
                                        input logic [2:0] f, input logic [1:0] s);
    logic [15:0] y;
    case (f)
      3'd0: y = a;
      3'd1: y = b;
      3'd2: y = a & b;
      3'd3: y = a | b;
      3'd4: y = ~a;
      3'd5: y = a + b;
      3'd6: y = a - b;
      default: y = a ^ b;
    endcase
    if (s == 2'd1) y = y << 1;
    else if (s == 2'd2) y = y >> 1;
    return y;
  endfunction

  // environment memory: responds to the design's port
  always @(posedge clk)
    if (rst_n && mem_req && mem_we && mem_ready) mem[mem_addr[7:0]] = mem_wdata;

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mr[i]) mr[i] = 16'h0;
      mres = 16'h0; mwbp = 1'b0; mwba = 3'd0;
    end else begin
      logic [15:0] y, mar_old;
      y = calc(rd(a_sel), rd(b_sel), alu_fn, sh_fn);
      mar_old = mr[6];
      if (mwbp) begin
        if (mwba == 3'd7) begin
          if (!mbr_sel) mr[7] = mres;
        end else if (mwba != 3'd1) mr[mwba] = mres;
      end
      if (ma && !wr && mem_ready && mbr_sel) mr[7] = mem[mar_old[7:0]];
      if (res_ld) mres = y;
      mwbp = res_ld;
      mwba = c_sel;
    end
  end

  // per-cycle comparison after the edge has settled
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R3 a_bus", a_bus, rd(a_sel));
      chk("R3 b_bus", b_bus, rd(b_sel));
      chk("R5 result", result, mres);
      chk("R7 mem_addr", mem_addr, mr[6]);
      chk("R7 mem_wdata", mem_wdata, mr[7]);
      chk("R7 mem_req/we", {14'h0, mem_req, mem_we}, {14'h0, ma, ma & wr});
    end
  end

  task automatic op(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                    input logic [2:0] f, input logic [1:0] s, input logic ld,
                    input logic sel, input logic m, input logic w, input logic rdy);
    @(negedge clk);
    a_sel = a; b_sel = b; c_sel = c; alu_fn = f; sh_fn = s;
    res_ld = ld; mbr_sel = sel; ma = m; wr = w; mem_ready = rdy;
  endtask

  task automatic nop();
    op(3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // apply op, wait for its edge, check the captured result
  task automatic alu_chk(input string req, input logic [2:0] f, input logic [1:0] s,
                         input logic [15:0] exp);
    op(3'd0, 3'd7, 3'd5, f, s, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    chk(req, result, exp);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    foreach (mem[i]) mem[i] = 16'h0;
    mem[8'h00] = 16'h0020;
    mem[8'h20] = 16'h1234;
    mem[8'h21] = 16'h00F0;
    rst_n = 1'b0;
    a_sel = 0; b_sel = 0; c_sel = 0; alu_fn = 0; sh_fn = 0;
    res_ld = 0; mbr_sel = 0; ma = 0; wr = 0; mem_ready = 0;
    repeat (3) @(posedge clk);
    // R1: reset state, scanned through the A bus
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); a_sel = 3'(i);
      #1 chk("R1 reset slot", a_bus, (i == 1) ? 16'h1 : 16'h0);
    end
    chk("R1 reset result", result, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    // R8: read mem[0] (MAR=0) with a stall first
    op(0,0,0,0,0,0, 1,1,0,0);
    @(posedge clk); #1 chk("R8 stalled read holds", mem_wdata, 16'h0);
    op(0,0,0,0,0,0, 1,1,0,1);
    @(posedge clk); #1 chk("R8 read loads", mem_wdata, 16'h0020);
    // MAR <- MBR, then read 0x20; move to TMP
    op(7,0,6,0,0,1, 0,0,0,0); nop();
    op(0,0,0,0,0,0, 1,1,0,1);
    op(7,0,0,0,0,1, 0,0,0,0); nop();
    // MAR <- MAR + 1, read 0x21
    op(6,1,6,5,0,1, 0,0,0,0); nop();
    op(0,0,0,0,0,0, 1,1,0,1);
    @(posedge clk); #1 chk("R8 second read", mem_wdata, 16'h00F0);

    // R4 / R5 with TMP=0x1234 on A and MBR=0x00F0 on B
    alu_chk("R4 pass A", 3'd0, 2'd0, 16'h1234);
    alu_chk("R4 pass B", 3'd1, 2'd0, 16'h00F0);
    alu_chk("R4 and", 3'd2, 2'd0, 16'h0030);
    alu_chk("R4 or", 3'd3, 2'd0, 16'h12F4);
    alu_chk("R4 not", 3'd4, 2'd0, 16'hEDCB);
    alu_chk("R4 add", 3'd5, 2'd0, 16'h1324);
    alu_chk("R4 sub", 3'd6, 2'd0, 16'h1144);
    alu_chk("R4 xor", 3'd7, 2'd0, 16'h12C4);
    alu_chk("R5 shift left", 3'd4, 2'd1, 16'hDB96);
    alu_chk("R5 shift right", 3'd4, 2'd2, 16'h76E5);
    alu_chk("R5 code 3", 3'd5, 2'd3, 16'h1324);
    op(0,0,0,0,0,0, 1,0,0,0);
    @(posedge clk); #1 chk("R5 hold", result, 16'h1324);

    // R11: reset, then ACC <- 2 and run the five-step add
    @(negedge clk); rst_n = 1'b0;
    mem[8'h00] = 16'h0010; mem[8'h10] = 16'h0007;
    @(negedge clk); rst_n = 1'b1;
    op(1,1,4,5,0,1, 0,0,0,0);
    op(4,0,0,0,0,0, 0,0,0,0);
    #2 chk("R6 no forwarding", a_bus, 16'h0);
    nop();
    op(2,0,6,0,0,1, 0,0,0,0); nop();          // MAR <- PC
    op(2,1,2,5,0,1, 1,1,0,1); nop();          // PC <- PC+1, memory read
    op(7,0,3,0,0,1, 0,0,0,0); nop();          // IR <- MBR
    op(3,0,6,0,0,1, 0,0,0,0); nop();          // MAR <- IR
    op(0,0,0,0,0,0, 1,1,0,1);                 // operand read
    op(4,7,4,5,0,1, 0,0,0,0); nop();          // ACC <- ACC + MBR
    op(4,2,0,0,0,0, 0,0,0,0);
    #2 chk("R11 accumulator", a_bus, 16'h0009);
    chk("R11 program counter", b_bus, 16'h0001);
    op(3,0,0,0,0,0, 0,0,0,0);
    #2 chk("R3 instruction slot", a_bus, 16'h0010);

    // R9: MBR <- ACC<<1 via C bus with mbr_sel=0
    op(4,0,7,0,1,1, 0,0,0,0); nop();
    @(posedge clk); #1 chk("R9 C-bus load", mem_wdata, 16'h0012);
    // R10: write with one stall cycle
    op(0,0,0,0,0,0, 0,1,1,0);
    @(posedge clk); #1 chk("R10 stalled write", mem[8'h10], 16'h0007);
    op(0,0,0,0,0,0, 0,1,1,1);
    @(posedge clk); #1 chk("R10 write done", mem[8'h10], 16'h0012);
    // R9: write-back to slot 7 dropped with mbr_sel=1
    op(1,0,7,0,0,1, 1,0,0,0);
    op(0,0,0,0,0,0, 1,0,0,0);
    @(posedge clk); #1 chk("R9 dropped write-back", mem_wdata, 16'h0012);
    // R2: write to slot 1 ignored
    op(4,0,1,0,0,1, 0,0,0,0); nop();
    op(1,1,0,0,0,0, 0,0,0,0);
    #2 chk("R2 constant A", a_bus, 16'h0001);
    chk("R2 constant B", b_bus, 16'h0001);
    nop(); nop();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule